// File: doc/BRIEF.md
# Register Alias Table Renamer

This block keeps, for every architectural register, a pointer to where the newest value of that register lives. The pointer targets either the committed register file or a numbered reorder-buffer entry. Each cycle a group of up to four micro-operations arrives, one per lane. Each one has two source registers and one destination register. The sources are translated through the table, so a consumer learns which entry will produce its operand. Every destination is handed the next reorder-buffer entry, counted from the buffer's tail pointer. The table is then redirected to that entry, so later readers see it. Because a fresh entry is handed out for every write, two writes to one register never share storage, and only true data dependencies remain.

When a reorder-buffer entry retires, its architectural register falls back to the committed file, unless a younger writer has already taken the pointer. A lane marked as a branch stores a copy of the table into a numbered slot. A recovery request loads the table back from a chosen slot. Retirements are applied to the stored copies as they happen, so a restored table never points at an entry that has already retired. Results are registered and appear one cycle after the group is presented.

Top module: `rat_renamer`

## Requirements
- R1: After reset every architectural register maps to the committed file, and all output lane valid bits are 0.
- R2: A valid lane i presented with tail pointer T reports destination entry (T + i) modulo NROB on `o_dst_idx` lane i, with `o_valid[i]` set, one clock later.
- R3: A source whose register maps to the committed file is reported with location bit 0 and index 0. A source whose register maps to an entry is reported with location bit 1 and that entry's number.
- R4: A source of lane i that names the destination of a valid earlier lane j < i in the same group takes lane j's new entry. When several earlier lanes qualify, the nearest one wins.
- R5: When several valid lanes of one group write the same register, the table afterwards holds the entry of the highest such lane.
- R6: A retire notice (register a, entry e) returns register a to the committed file only if the table maps a to entry e. A notice with any other entry leaves the mapping unchanged.
- R7: When a retire notice and a valid lane write the same register in the same cycle, the lane's new entry wins.
- R8: A valid lane with its branch bit set stores into slot `i_snap_slot` the table as it stands after that lane's own write. This includes earlier lanes' writes and excludes later lanes' writes. At most one lane per group carries the branch bit.
- R9: During a recovery cycle the table is replaced by the contents of slot `i_rec_slot`. The lanes presented in that cycle are ignored, and all output valid bits are 0 in the following cycle.
- R10: A retire notice that matches a mapping held in a stored slot clears that mapping in the slot too, so a later recovery from it shows the committed file.
- R11: Lanes with their valid bit clear neither change the table nor raise an output valid bit.
- R12: Destination entry numbers wrap past NROB-1 to 0 within a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | W | Per-lane uop valid |
| i_src_a | input | W*AW | Per-lane first source register |
| i_src_b | input | W*AW | Per-lane second source register |
| i_dst | input | W*AW | Per-lane destination register |
| i_branch | input | W | Per-lane branch marker (at most one set) |
| i_snap_slot | input | SW | Slot written by the branch lane |
| i_tail | input | IW | Reorder-buffer entry given to lane 0 |
| i_ret_valid | input | 1 | Retire notice valid |
| i_ret_arch | input | AW | Architectural register of the retiring entry |
| i_ret_idx | input | IW | Retiring reorder-buffer entry |
| i_rec_valid | input | 1 | Recovery request |
| i_rec_slot | input | SW | Slot to restore from |
| o_valid | output | W | Per-lane result valid |
| o_a_rob | output | W | First source location (1 = buffer entry, 0 = committed file) |
| o_a_idx | output | W*IW | First source entry number |
| o_b_rob | output | W | Second source location |
| o_b_idx | output | W*IW | Second source entry number |
| o_dst_idx | output | W*IW | Destination entry number |

## Verification
A corrupted table entry stays hidden until some later uop reads that register. It then shows up as a wrong location bit or entry number on that source output, one cycle after the reading group. Errors in the stored slots are delayed further: they appear only after a recovery, on the first group that reads the affected register. The bench therefore follows every retire and recovery with reads of the registers involved. It also uses a long mixed stream so that stale pointers are eventually read back.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic {
    LOC_ARF = 1'b0,
    LOC_ROB = 1'b1
  } loc_e;
endpackage

// File: rtl/rat_xlate.sv
module rat_xlate #(
  parameter int W     = 4,
  parameter int NARCH = 8,
  parameter int NROB  = 16
) (
  input  logic [NARCH-1:0][$clog2(NROB):0]   tab,
  input  logic [W-1:0]                       valid,
  input  logic [W-1:0]                       branch,
  input  logic [W-1:0][$clog2(NARCH)-1:0]    src_a,
  input  logic [W-1:0][$clog2(NARCH)-1:0]    src_b,
  input  logic [W-1:0][$clog2(NARCH)-1:0]    dst,
  input  logic [$clog2(NROB)-1:0]            tail,
  input  logic                               ret_valid,
  input  logic [$clog2(NARCH)-1:0]           ret_arch,
  input  logic [$clog2(NROB)-1:0]            ret_idx,
  output logic [W-1:0][$clog2(NROB):0]       ent_a,
  output logic [W-1:0][$clog2(NROB):0]       ent_b,
  output logic [NARCH-1:0][$clog2(NROB):0]   tab_nxt,
  output logic [NARCH-1:0][$clog2(NROB):0]   snap_tab,
  output logic                               snap_we
);
  import rat_pkg::*;
  localparam int AW = $clog2(NARCH);
  localparam int IW = $clog2(NROB);
  localparam int EW = IW + 1;

  // stage k holds the mapping seen by lane k (retire applied, lanes < k written)
  logic [NARCH-1:0][EW-1:0] stg [W+1];

  always_comb begin
    for (int r = 0; r < NARCH; r++) begin
      if (ret_valid && ret_arch == AW'(r) && tab[r] == {LOC_ROB, ret_idx})
        stg[0][r] = '0;
      else
        stg[0][r] = tab[r];
    end
    for (int k = 0; k < W; k++) begin
      stg[k+1] = stg[k];
      if (valid[k]) stg[k+1][dst[k]] = {LOC_ROB, tail + IW'(k)};
    end
    for (int i = 0; i < W; i++) begin
      ent_a[i] = stg[i][src_a[i]];
      ent_b[i] = stg[i][src_b[i]];
      if (ent_a[i][EW-1] == LOC_ARF) ent_a[i] = '0;
      if (ent_b[i][EW-1] == LOC_ARF) ent_b[i] = '0;
    end
    tab_nxt  = stg[W];
    snap_tab = stg[W];
    snap_we  = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (valid[k] && branch[k]) begin
        snap_we  = 1'b1;
        snap_tab = stg[k+1];
      end
    end
  end
endmodule

// File: rtl/rat_snap.sv
module rat_snap #(
  parameter int NSNAP = 4,
  parameter int NARCH = 8,
  parameter int NROB  = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ret_valid,
  input  logic [$clog2(NARCH)-1:0]          ret_arch,
  input  logic [$clog2(NROB)-1:0]           ret_idx,
  input  logic                              we,
  input  logic [$clog2(NSNAP)-1:0]          wslot,
  input  logic [NARCH-1:0][$clog2(NROB):0]  wtab,
  input  logic [$clog2(NSNAP)-1:0]          rslot,
  output logic [NARCH-1:0][$clog2(NROB):0]  rtab
);
  import rat_pkg::*;
  localparam int AW = $clog2(NARCH);
  localparam int IW = $clog2(NROB);
  localparam int SW = $clog2(NSNAP);
  localparam int EW = IW + 1;

  logic [NARCH-1:0][EW-1:0] mem [NSNAP];

  function automatic logic [EW-1:0] scrub(input logic [EW-1:0] ent, input int r,
                                          input logic rv, input logic [AW-1:0] ra,
                                          input logic [IW-1:0] ri);
    if (rv && ra == AW'(r) && ent == {LOC_ROB, ri}) return '0;
    return ent;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSNAP; s++) mem[s] <= '0;
    end else begin
      for (int s = 0; s < NSNAP; s++) begin
        for (int r = 0; r < NARCH; r++) begin
          if (we && wslot == SW'(s)) mem[s][r] <= wtab[r];
          else mem[s][r] <= scrub(mem[s][r], r, ret_valid, ret_arch, ret_idx);
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NARCH; r++)
      rtab[r] = scrub(mem[rslot][r], r, ret_valid, ret_arch, ret_idx);
  end
endmodule

// File: rtl/rat_renamer.sv
module rat_renamer #(
  parameter int W     = 4,
  parameter int NARCH = 8,
  parameter int NROB  = 16,
  parameter int NSNAP = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [W-1:0]                    i_valid,
  input  logic [W*$clog2(NARCH)-1:0]      i_src_a,
  input  logic [W*$clog2(NARCH)-1:0]      i_src_b,
  input  logic [W*$clog2(NARCH)-1:0]      i_dst,
  input  logic [W-1:0]                    i_branch,
  input  logic [$clog2(NSNAP)-1:0]        i_snap_slot,
  input  logic [$clog2(NROB)-1:0]         i_tail,
  input  logic                            i_ret_valid,
  input  logic [$clog2(NARCH)-1:0]        i_ret_arch,
  input  logic [$clog2(NROB)-1:0]         i_ret_idx,
  input  logic                            i_rec_valid,
  input  logic [$clog2(NSNAP)-1:0]        i_rec_slot,
  output logic [W-1:0]                    o_valid,
  output logic [W-1:0]                    o_a_rob,
  output logic [W*$clog2(NROB)-1:0]       o_a_idx,
  output logic [W-1:0]                    o_b_rob,
  output logic [W*$clog2(NROB)-1:0]       o_b_idx,
  output logic [W*$clog2(NROB)-1:0]       o_dst_idx
);
  import rat_pkg::*;
  localparam int AW = $clog2(NARCH);
  localparam int IW = $clog2(NROB);
  localparam int EW = IW + 1;

  logic [W-1:0][AW-1:0]     src_a, src_b, dst;
  logic [NARCH-1:0][EW-1:0] tab_q, tab_nxt, snap_wtab, snap_rtab;
  logic [W-1:0][EW-1:0]     ent_a, ent_b;
  logic                     snap_we_raw;
  logic                     ret_wr_hit;

  assign src_a = i_src_a;
  assign src_b = i_src_b;
  assign dst   = i_dst;

  rat_xlate #(.W(W), .NARCH(NARCH), .NROB(NROB)) u_xlate (
    .tab(tab_q), .valid(i_valid), .branch(i_branch),
    .src_a(src_a), .src_b(src_b), .dst(dst), .tail(i_tail),
    .ret_valid(i_ret_valid), .ret_arch(i_ret_arch), .ret_idx(i_ret_idx),
    .ent_a(ent_a), .ent_b(ent_b), .tab_nxt(tab_nxt),
    .snap_tab(snap_wtab), .snap_we(snap_we_raw)
  );

  rat_snap #(.NSNAP(NSNAP), .NARCH(NARCH), .NROB(NROB)) u_snap (
    .clk(clk), .rst(rst),
    .ret_valid(i_ret_valid), .ret_arch(i_ret_arch), .ret_idx(i_ret_idx),
    .we(snap_we_raw & ~i_rec_valid), .wslot(i_snap_slot), .wtab(snap_wtab),
    .rslot(i_rec_slot), .rtab(snap_rtab)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tab_q     <= '0;
      o_valid   <= '0;
      o_a_rob   <= '0;
      o_a_idx   <= '0;
      o_b_rob   <= '0;
      o_b_idx   <= '0;
      o_dst_idx <= '0;
    end else begin
      tab_q   <= i_rec_valid ? snap_rtab : tab_nxt;
      o_valid <= i_rec_valid ? '0 : i_valid;
      for (int i = 0; i < W; i++) begin
        o_a_rob[i]           <= ent_a[i][EW-1];
        o_a_idx[i*IW +: IW]  <= ent_a[i][IW-1:0];
        o_b_rob[i]           <= ent_b[i][EW-1];
        o_b_idx[i*IW +: IW]  <= ent_b[i][IW-1:0];
        o_dst_idx[i*IW +: IW] <= i_tail + IW'(i);
      end
    end
  end

  always_comb begin
    ret_wr_hit = 1'b0;
    for (int k = 0; k < W; k++)
      if (i_valid[k] && dst[k] == i_ret_arch) ret_wr_hit = 1'b1;
  end

  AST_REC_QUIET: assert property (@(posedge clk) disable iff (rst)
    i_rec_valid |=> (o_valid == '0)); // R9
  AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (rst)
    !i_rec_valid |-> ($countones(i_valid & i_branch) <= 1)); // R8
  AST_RET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (i_ret_valid && !i_rec_valid && !ret_wr_hit && tab_q[i_ret_arch] == {LOC_ROB, i_ret_idx})
      |=> (tab_q[$past(i_ret_arch)][EW-1] == LOC_ARF)); // R6
  AST_LAST_LANE_WINS: assert property (@(posedge clk) disable iff (rst)
    (i_valid[W-1] && !i_rec_valid)
      |=> (tab_q[$past(dst[W-1])] == {LOC_ROB, $past(i_tail) + IW'(W-1)})); // R5
  AST_GROUP_FWD: assert property (@(posedge clk) disable iff (rst)
    (i_valid[0] && i_valid[1] && !i_rec_valid && src_a[1] == dst[0])
      |=> (o_a_rob[1] && o_a_idx[IW +: IW] == $past(i_tail))); // R4
  AST_DST_SEQ: assert property (@(posedge clk) disable iff (rst)
    (o_valid[0] && o_valid[1]) |-> (o_dst_idx[IW +: IW] == o_dst_idx[IW-1:0] + IW'(1))); // R2
endmodule

// File: tb/rat_renamer_tb.sv
module rat_renamer_tb_top;
  localparam int W = 4, NA = 8, NR = 16, NS = 4, AW = 3, IW = 4, SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] i_valid = '0, i_branch = '0;
  logic [W*AW-1:0] i_src_a = '0, i_src_b = '0, i_dst = '0;
  logic [SW-1:0] i_snap_slot = '0, i_rec_slot = '0;
  logic [IW-1:0] i_tail = '0, i_ret_idx = '0;
  logic i_ret_valid = 1'b0, i_rec_valid = 1'b0;
  logic [AW-1:0] i_ret_arch = '0;
  logic [W-1:0] o_valid, o_a_rob, o_b_rob;
  logic [W*IW-1:0] o_a_idx, o_b_idx, o_dst_idx;

  always #5 clk = ~clk;

  rat_renamer #(.W(W), .NARCH(NA), .NROB(NR), .NSNAP(NS)) dut_i (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_src_a(i_src_a), .i_src_b(i_src_b),
    .i_dst(i_dst), .i_branch(i_branch), .i_snap_slot(i_snap_slot), .i_tail(i_tail),
    .i_ret_valid(i_ret_valid), .i_ret_arch(i_ret_arch), .i_ret_idx(i_ret_idx),
    .i_rec_valid(i_rec_valid), .i_rec_slot(i_rec_slot), .o_valid(o_valid),
    .o_a_rob(o_a_rob), .o_a_idx(o_a_idx), .o_b_rob(o_b_rob), .o_b_idx(o_b_idx),
    .o_dst_idx(o_dst_idx)
  );

  typedef struct {
    logic [W-1:0] v;
    int ar[W]; int ai[W]; int br[W]; int bi[W]; int di[W];
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  // reference mapping: location flag and entry per register, plus stored slots
  int mr[NA], mi[NA], sr[NS][NA], si[NS][NA];
  // stimulus for the next group
  int lv[W], la[W], lb[W], ld[W], lbr[W];
  int t = 0, slot = 0, rv = 0, ra = 0, ri = 0, rec = 0, rslot = 0;
  int seed = 32'h1357_9bdf;

  function automatic int rnd(int n);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return (seed & 32'h7fff_ffff) % n;
  endfunction

  task automatic clr();
    for (int i = 0; i < W; i++) begin lv[i] = 0; la[i] = 0; lb[i] = 0; ld[i] = 0; lbr[i] = 0; end
    slot = 0; rv = 0; ra = 0; ri = 0; rec = 0; rslot = 0;
  endtask

  task automatic go(string tag);
    exp_t e;
    for (int i = 0; i < W; i++) begin
      i_valid[i] = lv[i][0]; i_branch[i] = lbr[i][0];
      i_src_a[i*AW +: AW] = AW'(la[i]); i_src_b[i*AW +: AW] = AW'(lb[i]);
      i_dst[i*AW +: AW] = AW'(ld[i]);
    end
    i_tail = IW'(t); i_snap_slot = SW'(slot); i_ret_valid = rv[0];
    i_ret_arch = AW'(ra); i_ret_idx = IW'(ri); i_rec_valid = rec[0]; i_rec_slot = SW'(rslot);
    e.tag = tag;
    if (rv != 0) begin
      for (int s = 0; s < NS; s++)
        if (sr[s][ra] == 1 && si[s][ra] == ri) begin sr[s][ra] = 0; si[s][ra] = 0; end
      if (mr[ra] == 1 && mi[ra] == ri) begin mr[ra] = 0; mi[ra] = 0; end
    end
    for (int i = 0; i < W; i++) begin
      e.ar[i] = 0; e.ai[i] = 0; e.br[i] = 0; e.bi[i] = 0; e.di[i] = 0;
    end
    if (rec != 0) begin
      e.v = '0;
      for (int r = 0; r < NA; r++) begin mr[r] = sr[rslot][r]; mi[r] = si[rslot][r]; end
    end else begin
      for (int i = 0; i < W; i++) begin
        e.v[i] = lv[i][0];
        if (lv[i] != 0) begin
          e.ar[i] = mr[la[i]]; e.ai[i] = mi[la[i]];
          e.br[i] = mr[lb[i]]; e.bi[i] = mi[lb[i]];
          e.di[i] = (t + i) % NR;
          mr[ld[i]] = 1; mi[ld[i]] = (t + i) % NR;
          if (lbr[i] != 0)
            for (int r = 0; r < NA; r++) begin sr[slot][r] = mr[r]; si[slot][r] = mi[r]; end
        end
      end
    end
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compares one expected item per clock, just after the edge
  always begin
    @(posedge clk);
    #1;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (o_valid !== e.v) begin
        fails++;
        $display("FAIL %s valid: got %b exp %b", e.tag, o_valid, e.v);
      end
      for (int i = 0; i < W; i++) begin
        if (e.v[i]) begin
          checks += 3;
          if (int'(o_a_rob[i]) != e.ar[i] || int'(o_a_idx[i*IW +: IW]) != e.ai[i]) begin
            fails++;
            $display("FAIL %s lane %0d src_a: got %0d/%0d exp %0d/%0d", e.tag, i,
                     o_a_rob[i], o_a_idx[i*IW +: IW], e.ar[i], e.ai[i]);
          end
          if (int'(o_b_rob[i]) != e.br[i] || int'(o_b_idx[i*IW +: IW]) != e.bi[i]) begin
            fails++;
            $display("FAIL %s lane %0d src_b: got %0d/%0d exp %0d/%0d", e.tag, i,
                     o_b_rob[i], o_b_idx[i*IW +: IW], e.br[i], e.bi[i]);
          end
          if (int'(o_dst_idx[i*IW +: IW]) != e.di[i]) begin
            fails++;
            $display("FAIL %s lane %0d dst: got %0d exp %0d", e.tag, i,
                     o_dst_idx[i*IW +: IW], e.di[i]);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got hang exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < NA; r++) begin
      mr[r] = 0; mi[r] = 0;
      for (int s = 0; s < NS; s++) begin sr[s][r] = 0; si[s][r] = 0; end
    end
    clr();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (o_valid !== '0) begin
      fails++;
      $display("FAIL R1 reset valid: got %b exp 0", o_valid);
    end
    // R1: every register reads the committed file; R5: all lanes write reg 0
    clr();
    for (int i = 0; i < W; i++) begin lv[i] = 1; la[i] = i; lb[i] = i + 4; ld[i] = 0; end
    go("R1"); t = (t + 4) % NR;
    // R5 / R3: reg 0 now maps to the last lane's entry
    clr(); lv[0] = 1; la[0] = 0; lb[0] = 1; ld[0] = 7;
    go("R5"); t = (t + 4) % NR;
    // R4: in-group forwarding, nearest earlier writer wins
    clr();
    lv[0] = 1; ld[0] = 1; la[0] = 2;
    lv[1] = 1; la[1] = 1; lb[1] = 0; ld[1] = 2;
    lv[2] = 1; la[2] = 2; ld[2] = 1;
    lv[3] = 1; la[3] = 1; lb[3] = 2; ld[3] = 3;
    go("R4"); t = (t + 4) % NR;
    // R11: invalid lanes write reg 5, then reg 5 must still be committed
    clr(); lv[1] = 1; ld[1] = 6; ld[0] = 5; ld[2] = 5; ld[3] = 5;
    go("R11");
    clr(); lv[0] = 1; la[0] = 5; lb[0] = 6; ld[0] = 4;
    go("R11"); t = (t + 4) % NR;
    // R12: wrap inside a group
    t = 14;
    clr(); for (int i = 0; i < W; i++) begin lv[i] = 1; la[i] = i; ld[i] = 4 + i; end
    go("R12"); t = (t + 4) % NR;
    // R6: stale retire ignored, matching retire clears
    clr(); rv = 1; ra = 4; ri = (mi[4] + 1) % NR; lv[0] = 1; la[0] = 4; ld[0] = 0;
    go("R6");
    clr(); lv[0] = 1; la[0] = 4; lb[0] = 7; ld[0] = 0;
    go("R6"); t = (t + 4) % NR;
    clr(); rv = 1; ra = 7; ri = mi[7]; lv[0] = 1; la[0] = 7; lb[0] = 7; ld[0] = 0;
    go("R6");
    clr(); lv[0] = 1; la[0] = 7; ld[0] = 0;
    go("R6"); t = (t + 4) % NR;
    // R7: retire and write of the same reg in one cycle
    clr(); rv = 1; ra = 6; ri = mi[6]; lv[2] = 1; ld[2] = 6;
    go("R7"); t = (t + 4) % NR;
    clr(); lv[0] = 1; la[0] = 6; ld[0] = 0;
    go("R7"); t = (t + 4) % NR;
    // R8 / R10 / R9: snapshot at lane 1, overwrite, retire in snapshot, recover
    clr(); slot = 2;
    lv[0] = 1; ld[0] = 3; lv[1] = 1; ld[1] = 4; lbr[1] = 1; lv[2] = 1; ld[2] = 5; lv[3] = 1; ld[3] = 6;
    go("R8"); t = (t + 4) % NR;
    clr(); for (int i = 0; i < W; i++) begin lv[i] = 1; ld[i] = 3 + i; end
    go("R8"); t = (t + 4) % NR;
    clr(); rv = 1; ra = 3; ri = si[2][3];
    go("R10");
    clr(); rec = 1; rslot = 2; lv[0] = 1; ld[0] = 2; la[0] = 3;
    go("R9");
    clr();
    for (int i = 0; i < W; i++) begin lv[i] = 1; la[i] = 3 + i; lb[i] = 2; ld[i] = 0; end
    go("R9"); t = (t + 4) % NR;
    // mixed stream
    for (int n = 0; n < 400; n++) begin
      clr();
      for (int i = 0; i < W; i++) begin
        lv[i] = rnd(4) != 0; la[i] = rnd(NA); lb[i] = rnd(NA); ld[i] = rnd(NA);
      end
      if (rnd(3) == 0) begin lbr[rnd(W)] = 1; slot = rnd(NS); end
      if (rnd(2) == 0) begin
        rv = 1; ra = rnd(NA); ri = (rnd(4) != 0) ? mi[ra] : rnd(NR);
      end
      if (rnd(10) == 0) begin rec = 1; rslot = rnd(NS); end
      go("R3");
      t = (t + 4) % NR;
    end
    clr(); go("R11");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule